// File: doc/BRIEF.md
# Banked Replicated Multi-Read Memory

This block is an on-chip store for a two-dimensional array of `ROWS` x `VEC` words. It accepts `VEC * VEC` reads in every clock cycle and never stalls a reader. The array is split by column, so column `k` of every row sits in bank `k`. Each bank is then held in `VEC` identical copies, called replicates. Each copy is a simple dual-port store with one write port and one read port, and no port of a copy handles both reads and writes.

There is one write port per bank. A write carries a row index and a data word, and it is broadcast to every copy of that bank in the same cycle, so all copies stay identical. Read port `p` is wired to one bank and one copy: it reads column `p / VEC` through copy `p % VEC`. Only its row index is supplied at run time. Read data is registered and appears one clock after the row index is presented.

The array is loaded with ordinary writes. Reset clears the stored words and the read registers to zero.

Top module: `bank_rep_mem`

## Requirements
- R1: While reset is asserted, and after it is released with no writes since, every read port returns zero.
- R2: The word for the row index sampled at clock edge t appears on the read port after edge t. The output changes at no other edge.
- R3: Read port p returns column p / VEC of its row; write port k changes column k only. Ports are packed from bit 0 upward, with read port p's row in bits [p*RW +: RW] and data in bits [p*DW +: DW], where RW = log2(ROWS).
- R4: A write to bank k becomes visible on all VEC read ports of bank k.
- R5: All VEC * VEC read ports deliver independent rows in the same cycle, and no reader is ever held off.
- R6: A read of a row and column that is also written in the same cycle returns the old word. The new word is seen from the next read on.
- R7: A write to one row leaves every other row of the same bank unchanged.
- R8: All VEC write ports may write different rows in the same cycle, and each write lands in its own bank.
- R9: When a write port's enable is low, its row and data inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | VEC | Write enable, one bit per bank |
| wr_row | input | VEC*RW | Write row index for each bank |
| wr_data | input | VEC*DW | Write data for each bank |
| rd_row | input | VEC*VEC*RW | Row index for each read port |
| rd_data | output | VEC*VEC*DW | Registered read data for each read port |

## Verification
Every read result is due exactly one rising edge after its row index is applied, and a write becomes readable from the edge that follows the write edge. The bench changes inputs on the falling edge and samples outputs on the next falling edge, which is half a cycle after the single edge each result depends on. The read-before-write case keeps the row index fixed across two edges: it expects the old word after the first edge and the new word after the second.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  // Bank (column) served by a read port.
  function automatic int port_bank(input int p, input int vec);
    return p / vec;
  endfunction

  // Replicate inside that bank serving the read port.
  function automatic int port_copy(input int p, input int vec);
    return p % vec;
  endfunction
endpackage

// File: rtl/bmr_replica.sv
module bmr_replica #(
  parameter int ROWS = 8,
  parameter int DW   = 16,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] raddr,
  output logic [DW-1:0] rd_q
);
  logic [DW-1:0] store [ROWS];

  // One write port and one read port; the read samples the pre-write contents.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
      for (int i = 0; i < ROWS; i++) store[i] <= '0;
    end else begin
      rd_q <= store[raddr];
      if (we) store[waddr] <= wdata;
    end
  end

  // A word written then read back on the next cycle is returned.
  assert_write_then_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we ##1 (!we && raddr == $past(waddr)) |=> rd_q == $past(wdata, 2));

  // Same row, no write in between: output holds.
  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(raddr) && !$past(we)) |=> $stable(rd_q));

  // Collision of read and write on one row yields the old word.
  assert_read_before_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(raddr) && !$past(we) && we && raddr == waddr) |=> rd_q == $past(rd_q));
endmodule

// File: rtl/bmr_bank.sv
module bmr_bank #(
  parameter int ROWS = 8,
  parameter int VEC  = 4,
  parameter int DW   = 16,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [VEC*RW-1:0] raddr,
  output logic [VEC*DW-1:0] rdata
);
  for (genvar j = 0; j < VEC; j++) begin : g_copy
    // Every copy sees the same write: broadcast keeps them identical.
    bmr_replica #(.ROWS(ROWS), .DW(DW)) u_copy (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr[j*RW +: RW]),
      .rd_q  (rdata[j*DW +: DW])
    );

    if (j > 0) begin : g_coh
      // Copies reading the same row agree.
      assert_copies_coherent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr[j*RW +: RW] == raddr[RW-1:0]) |=> (rdata[j*DW +: DW] == rdata[DW-1:0]));
    end
  end
endmodule

// File: rtl/bank_rep_mem.sv
module bank_rep_mem #(
  parameter int ROWS = 8,
  parameter int VEC  = 4,
  parameter int DW   = 16,
  localparam int RW     = $clog2(ROWS),
  localparam int NPORTS = VEC * VEC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [VEC-1:0]       wr_en,
  input  logic [VEC*RW-1:0]    wr_row,
  input  logic [VEC*DW-1:0]    wr_data,
  input  logic [NPORTS*RW-1:0] rd_row,
  output logic [NPORTS*DW-1:0] rd_data
);
  import bmr_pkg::*;

  initial begin
    assert ((1 << RW) == ROWS) else $error("ROWS must be a power of two");
    assert ((VEC & (VEC - 1)) == 0 && VEC > 0) else $error("VEC must be a power of two");
  end

  for (genvar k = 0; k < VEC; k++) begin : g_bank
    logic [VEC*RW-1:0] bank_raddr;
    logic [VEC*DW-1:0] bank_rdata;

    // Gather the read ports whose column equals k.
    for (genvar p = 0; p < NPORTS; p++) begin : g_sel
      if (port_bank(p, VEC) == k) begin : g_hit
        assign bank_raddr[port_copy(p, VEC)*RW +: RW] = rd_row[p*RW +: RW];
        assign rd_data[p*DW +: DW] = bank_rdata[port_copy(p, VEC)*DW +: DW];
      end
    end

    bmr_bank #(.ROWS(ROWS), .VEC(VEC), .DW(DW)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en[k]),
      .waddr (wr_row[k*RW +: RW]),
      .wdata (wr_data[k*DW +: DW]),
      .raddr (bank_raddr),
      .rdata (bank_rdata)
    );
  end
endmodule

// File: tb/bank_rep_mem_tb.sv
module bank_rep_mem_tb;
  localparam int ROWS = 8;
  localparam int VEC  = 4;
  localparam int DW   = 16;
  localparam int RW   = 3;
  localparam int NP   = VEC * VEC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [VEC-1:0]    wr_en = '0;
  logic [VEC*RW-1:0] wr_row = '0;
  logic [VEC*DW-1:0] wr_data = '0;
  logic [NP*RW-1:0]  rd_row = '0;
  logic [NP*DW-1:0]  rd_data;

  int n_checks = 0;
  int n_fail = 0;
  logic [DW-1:0] model [ROWS][VEC];

  always #10 clk = ~clk;

  bank_rep_mem #(.ROWS(ROWS), .VEC(VEC), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_data(wr_data), .rd_row(rd_row), .rd_data(rd_data));

  function automatic logic [DW-1:0] pattern(input int r, input int c);
    return DW'(16'h1000 * (c + 1) + r * 16'h0011);
  endfunction

  task automatic check(input string req, input int p, input logic [DW-1:0] exp);
    n_checks++;
    if (rd_data[p*DW +: DW] !== exp) begin
      n_fail++;
      $display("FAIL %s port %0d: got %h expected %h", req, p, rd_data[p*DW +: DW], exp);
    end
  endtask

  task automatic set_read(input int p, input int r);
    rd_row[p*RW +: RW] = RW'(r);
  endtask

  task automatic set_write(input int k, input int r, input logic [DW-1:0] d);
    wr_en[k] = 1'b1;
    wr_row[k*RW +: RW] = RW'(r);
    wr_data[k*DW +: DW] = d;
  endtask

  // R1: outputs zero during and after reset.
  task automatic t_reset();
    for (int p = 0; p < NP; p++) set_read(p, p % ROWS);
    @(negedge clk);
    for (int p = 0; p < NP; p++) check("R1", p, '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < NP; p++) check("R1", p, '0);
  endtask

  // R8, R3, R5: fill all banks in parallel, then read every port with distinct rows.
  task automatic t_fill();
    for (int r = 0; r < ROWS; r++) begin
      for (int k = 0; k < VEC; k++) begin
        set_write(k, (r + k) % ROWS, pattern((r + k) % ROWS, k));
        model[(r + k) % ROWS][k] = pattern((r + k) % ROWS, k);
      end
      @(negedge clk);
    end
    wr_en = '0;
    for (int p = 0; p < NP; p++) set_read(p, (p * 3 + 1) % ROWS);
    @(negedge clk);
    for (int p = 0; p < NP; p++) check("R5", p, model[(p * 3 + 1) % ROWS][p / VEC]);
    for (int p = 0; p < NP; p++) set_read(p, ROWS - 1 - (p % ROWS));
    @(negedge clk);
    for (int p = 0; p < NP; p++) check("R3", p, model[ROWS - 1 - (p % ROWS)][p / VEC]);
  endtask

  // R4, R7: one write to bank 2, seen by all its copies; other rows untouched.
  task automatic t_broadcast();
    set_write(2, 5, 16'hBEEF);
    model[5][2] = 16'hBEEF;
    @(negedge clk);
    wr_en = '0;
    for (int p = 0; p < NP; p++) set_read(p, 5);
    @(negedge clk);
    for (int p = 0; p < NP; p++) check("R4", p, model[5][p / VEC]);
    for (int p = 0; p < NP; p++) set_read(p, (p % VEC == 0) ? 4 : 6 + (p % 2));
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      check("R7", p, model[(p % VEC == 0) ? 4 : 6 + (p % 2)][p / VEC]);
  endtask

  // R6, R2: colliding read and write returns old, then new one edge later.
  task automatic t_collide();
    for (int p = 0; p < NP; p++) set_read(p, 3);
    @(negedge clk);
    for (int k = 0; k < VEC; k++) set_write(k, 3, DW'(16'hA000 + k));
    @(negedge clk);
    wr_en = '0;
    for (int p = 0; p < NP; p++) check("R6", p, model[3][p / VEC]);
    for (int k = 0; k < VEC; k++) model[3][k] = DW'(16'hA000 + k);
    @(negedge clk);
    for (int p = 0; p < NP; p++) check("R2", p, model[3][p / VEC]);
  endtask

  // R9: disabled write ports carry junk that must not land.
  task automatic t_ignore();
    for (int k = 0; k < VEC; k++) begin
      wr_row[k*RW +: RW] = RW'(1);
      wr_data[k*DW +: DW] = 16'hDEAD;
    end
    wr_en = '0;
    for (int p = 0; p < NP; p++) set_read(p, 1);
    @(negedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) check("R9", p, model[1][p / VEC]);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_broadcast();
    t_collide();
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule